// File: doc/BRIEF.md
# Rotating Register Window Translator

This block turns a logical register number into an index into a physical register file of `FILE_SIZE` entries. It holds the window and rotation state of the current procedure: window base, window size, a fixed-frame flag, a double flag, the base and size of a rotating area inside the window, and the current rotation step. A request names a register and whether it is a plain window register or a rotating (based) register. The registered result, or a fault, appears one cycle later.

Plain window registers are the offset plus twice the window base, wrapped around the file. Based registers are first rotated modulo the span of the rotating area, which is twice its size plus two. They are then placed at twice the window base plus twice the area base, again wrapped around the file. The state changes on three commands: window set, base set and call. It also changes at the end of each bundle, when the rotation step advances. Whether it advances depends on whether that bundle branched.

Top module: `regwin_xlate`

## Requirements
- R1: After reset all state is zero: window base, window size, area base, area size, rotation step, fixed flag and double flag. `xl_valid`, `fault`, `frame_fixed` and `frame_dbl` are low, so any translation request faults because the window size is zero.
- R2: A window request (`xl_based`=0) for register r returns (r + 2*wbs) mod FILE_SIZE on `xl_idx`.
- R3: A window request faults when r >= 64 or r >= 2*wsz. A faulting request returns `xl_idx`=0 with `fault`=1 and changes no state.
- R4: A based request (`xl_based`=1) computes span = 2*rsz+2 and i = (r + 2*(rsz+1-rcur)) mod span. It returns (i + 2*wbs + 2*rbs) mod FILE_SIZE.
- R5: A based request faults when r >= 2*wsz or r >= span, with `xl_idx`=0.
- R6: The base-set command takes rcur from `cmd_param[17:12]`, rsz from `cmd_param[11:6]` and rbs from `cmd_param[5:0]`. If that rcur exceeds that rsz, the command is rejected: `fault` is 1 in the next cycle and rbs, rsz and rcur keep their values.
- R7: The window-set command takes wsz from `cmd_lit[11:5]` and the fixed flag from `cmd_lit[4]`, the latter shown on `frame_fixed`. It takes the double flag from `cmd_lit[3]` onto `frame_dbl` only when `core_ver` >= 3. Otherwise the double flag keeps its value.
- R8: The call command sets the window base to `cmd_param[6:0]` and ignores the higher bits.
- R9: When `bundle_end` is high, rcur advances to (rcur+1) mod (rsz+1). For a non-branching bundle it advances only if `bundle_rot[1]` is set. For a branching bundle (`bundle_branch`=1) it advances only if `bundle_rot[0]` is set.
- R10: An accepted base-set command in the same cycle as an advancing bundle end wins, and the loaded rcur is kept. A translation in the same cycle uses the state from before that edge.
- R11: `xl_valid` is high exactly in the cycle after a cycle with `xl_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_req | input | 1 | Translation request strobe |
| xl_based | input | 1 | 1 = rotating register, 0 = window register |
| xl_reg | input | 7 | Logical register number |
| cmd_win | input | 1 | Window-set command strobe |
| cmd_base | input | 1 | Base-set command strobe |
| cmd_call | input | 1 | Call command strobe |
| cmd_param | input | 32 | Parameter word for base-set and call |
| cmd_lit | input | 32 | Literal word for window-set |
| core_ver | input | 4 | Core version level, gates the double flag |
| bundle_end | input | 1 | End-of-bundle strobe |
| bundle_branch | input | 1 | The ending bundle branched |
| bundle_rot | input | 2 | Rotation control: bit 1 non-branch, bit 0 branch |
| xl_valid | output | 1 | Result valid |
| xl_idx | output | $clog2(FILE_SIZE) | Physical register index |
| fault | output | 1 | Bound violation on the request or rejected base-set |
| frame_fixed | output | 1 | Fixed-frame flag |
| frame_dbl | output | 1 | Double flag |

## Verification
On every cycle the assertions check several properties. Results arrive exactly one cycle after requests. A faulting result carries index zero. The rotation step never passes the area size. A call loads the low seven parameter bits. The double flag holds across a window-set below version 3. A rejected base-set faults and keeps the area fields. With no command and no bundle end, the state stays put. The index arithmetic can only be shown by the bench scenarios: the rotated offset modulo the span, the double wrap around the file, the branch-dependent choice of control bit, the wrap of the rotation step and the precedence of a base-set over rotation. There the scoreboard compares each result with a model built from the formulas.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   // Field widths fixed by the command formats
   localparam int WBS_W = 7;
   localparam int WSZ_W = 7;
   localparam int RA_W  = 6;
   localparam int REG_W = 7;
   localparam int VER_W = 4;

   // Lowest register number outside any plain window
   localparam int WIN_REG_LIMIT = 64;
   // Version level at which the double flag is honoured
   localparam int DBL_MIN_VER = 3;

   // Base-set parameter layout
   localparam int BS_RCUR_LO = 12;
   localparam int BS_RSZ_LO  = 6;
   localparam int BS_RBS_LO  = 0;
   // Window-set literal layout
   localparam int WS_WSZ_LO = 5;
   localparam int WS_FIX_B  = 4;
   localparam int WS_DBL_B  = 3;

   typedef struct packed {
      logic [WBS_W-1:0] wbs;
      logic [WSZ_W-1:0] wsz;
      logic             fixd;
      logic             dbl;
      logic [RA_W-1:0]  rbs;
      logic [RA_W-1:0]  rsz;
      logic [RA_W-1:0]  rcur;
   } win_state_t;
endpackage

// File: rtl/regwin_modsub.sv
module regwin_modsub #(
   parameter int W    = 10,
   parameter int MOD  = 256,
   parameter int NSUB = 1
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] r
);
   localparam logic [W-1:0] MODV = W'(MOD);

   generate
      if (NSUB == 0) begin : g_pass
         assign r = a;
      end else begin : g_chain
         logic [W-1:0] stg [NSUB+1];
         assign stg[0] = a;
         for (genvar k = 0; k < NSUB; k++) begin : g_stage
            assign stg[k+1] = (stg[k] >= MODV) ? (stg[k] - MODV) : stg[k];
         end
         assign r = stg[NSUB];
      end
   endgenerate
endmodule

// File: rtl/regwin_state.sv
module regwin_state
   import regwin_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_win,
   input  logic             cmd_base,
   input  logic             cmd_call,
   input  logic [31:0]      cmd_param,
   input  logic [31:0]      cmd_lit,
   input  logic [VER_W-1:0] core_ver,
   input  logic             bundle_end,
   input  logic             bundle_branch,
   input  logic [1:0]       bundle_rot,
   output win_state_t       st_q,
   output logic             base_bad
);
   win_state_t      st_d;
   logic [RA_W-1:0] new_rcur, new_rsz, new_rbs;
   logic            rot_fire;

   assign new_rcur = cmd_param[BS_RCUR_LO +: RA_W];
   assign new_rsz  = cmd_param[BS_RSZ_LO  +: RA_W];
   assign new_rbs  = cmd_param[BS_RBS_LO  +: RA_W];
   assign base_bad = cmd_base && (new_rcur > new_rsz);
   assign rot_fire = bundle_end && (bundle_branch ? bundle_rot[0] : bundle_rot[1]);

   always_comb begin
      st_d = st_q;
      if (rot_fire) begin
         st_d.rcur = (st_q.rcur == st_q.rsz) ? '0 : st_q.rcur + 1'b1;
      end
      if (cmd_win) begin
         st_d.wsz  = cmd_lit[WS_WSZ_LO +: WSZ_W];
         st_d.fixd = cmd_lit[WS_FIX_B];
         if (core_ver >= VER_W'(DBL_MIN_VER)) begin
            st_d.dbl = cmd_lit[WS_DBL_B];
         end
      end
      if (cmd_call) begin
         st_d.wbs = cmd_param[WBS_W-1:0];
      end
      if (cmd_base && !base_bad) begin
         st_d.rcur = new_rcur;
         st_d.rsz  = new_rsz;
         st_d.rbs  = new_rbs;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/regwin_map.sv
module regwin_map
   import regwin_pkg::*;
#(
   parameter int FILE_SIZE = 256
) (
   input  win_state_t                     st,
   input  logic                           based,
   input  logic [REG_W-1:0]               rnum,
   output logic [$clog2(FILE_SIZE)-1:0]   idx,
   output logic                           oob
);
   localparam int PW    = $clog2(FILE_SIZE);
   localparam int SW    = (PW > 9) ? PW + 1 : 10;
   localparam int MAX_W = (WIN_REG_LIMIT - 1) + 2 * ((1 << WBS_W) - 1);
   localparam int MAX_B = (2 << RA_W) - 1 + 2 * ((1 << WBS_W) - 1) + 2 * ((1 << RA_W) - 1);
   localparam int NS_W  = MAX_W / FILE_SIZE;
   localparam int NS_B  = MAX_B / FILE_SIZE;

   logic [7:0]    win_lim, span, off, r8;
   logic [6:0]    rs1, diff;
   logic [8:0]    t9, span9, rot_i;
   logic [SW-1:0] sum_w, sum_b, red_w, red_b, pick;
   logic          oob_w, oob_b;

   assign r8      = {1'b0, rnum};
   assign win_lim = {st.wsz, 1'b0};

   // plain window path
   assign oob_w = (r8 >= 8'(WIN_REG_LIMIT)) || (r8 >= win_lim);
   assign sum_w = SW'(rnum) + SW'({st.wbs, 1'b0});

   // rotating path
   assign span  = {1'b0, st.rsz, 1'b0} + 8'd2;
   assign rs1   = {1'b0, st.rsz} + 7'd1;
   assign diff  = rs1 - {1'b0, st.rcur};
   assign off   = {diff, 1'b0};
   assign t9    = {2'b00, rnum} + {1'b0, off};
   assign span9 = {1'b0, span};
   assign rot_i = (t9 >= span9) ? (t9 - span9) : t9;
   assign oob_b = (r8 >= win_lim) || (r8 >= span);
   assign sum_b = SW'(rot_i) + SW'({st.wbs, 1'b0}) + SW'({st.rbs, 1'b0});

   regwin_modsub #(.W(SW), .MOD(FILE_SIZE), .NSUB(NS_W)) u_red_w (.a(sum_w), .r(red_w));
   regwin_modsub #(.W(SW), .MOD(FILE_SIZE), .NSUB(NS_B)) u_red_b (.a(sum_b), .r(red_b));

   assign pick = based ? red_b : red_w;
   assign idx  = pick[PW-1:0];
   assign oob  = based ? oob_b : oob_w;
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
   import regwin_pkg::*;
#(
   parameter int FILE_SIZE = 256
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          xl_req,
   input  logic                          xl_based,
   input  logic [6:0]                    xl_reg,
   input  logic                          cmd_win,
   input  logic                          cmd_base,
   input  logic                          cmd_call,
   input  logic [31:0]                   cmd_param,
   input  logic [31:0]                   cmd_lit,
   input  logic [3:0]                    core_ver,
   input  logic                          bundle_end,
   input  logic                          bundle_branch,
   input  logic [1:0]                    bundle_rot,
   output logic                          xl_valid,
   output logic [$clog2(FILE_SIZE)-1:0]  xl_idx,
   output logic                          fault,
   output logic                          frame_fixed,
   output logic                          frame_dbl
);
   localparam int PW = $clog2(FILE_SIZE);

   generate
      if (FILE_SIZE < 2 || FILE_SIZE > 4096) begin : g_bad_size
         $error("regwin_xlate: FILE_SIZE out of supported range");
      end
   endgenerate

   win_state_t    st_q;
   logic          base_bad;
   logic [PW-1:0] map_idx;
   logic          map_oob;

   regwin_state u_state (
      .clk(clk), .rst_n(rst_n),
      .cmd_win(cmd_win), .cmd_base(cmd_base), .cmd_call(cmd_call),
      .cmd_param(cmd_param), .cmd_lit(cmd_lit), .core_ver(core_ver),
      .bundle_end(bundle_end), .bundle_branch(bundle_branch), .bundle_rot(bundle_rot),
      .st_q(st_q), .base_bad(base_bad)
   );

   regwin_map #(.FILE_SIZE(FILE_SIZE)) u_map (
      .st(st_q), .based(xl_based), .rnum(xl_reg),
      .idx(map_idx), .oob(map_oob)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_valid <= 1'b0;
         xl_idx   <= '0;
         fault    <= 1'b0;
      end else begin
         xl_valid <= xl_req;
         xl_idx   <= (xl_req && !map_oob) ? map_idx : '0;
         fault    <= (xl_req && map_oob) || base_bad;
      end
   end

   assign frame_fixed = st_q.fixd;
   assign frame_dbl   = st_q.dbl;
endmodule

// File: rtl/regwin_xlate_chk.sv
module regwin_xlate_chk
   import regwin_pkg::*;
#(
   parameter int FILE_SIZE = 256
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          xl_req,
   input logic                          cmd_win,
   input logic                          cmd_base,
   input logic                          cmd_call,
   input logic [31:0]                   cmd_param,
   input logic [3:0]                    core_ver,
   input logic                          bundle_end,
   input logic                          xl_valid,
   input logic [$clog2(FILE_SIZE)-1:0]  xl_idx,
   input logic                          fault,
   input win_state_t                    st
);
   assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req |=> xl_valid);
   assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_req |=> !xl_valid);
   assert_fault_idx_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && fault) |-> (xl_idx == '0));
   assert_rcur_in_area_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st.rcur <= st.rsz);
   assert_call_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_call |=> (st.wbs == $past(cmd_param[6:0])));
   assert_dbl_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_win && core_ver < 4'd3) |=> $stable(st.dbl));
   assert_bad_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_base && cmd_param[17:12] > cmd_param[11:6]) |=>
         (fault && $stable(st.rsz) && $stable(st.rbs)));
   assert_idle_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_win && !cmd_base && !cmd_call && !bundle_end) |=> $stable(st));
endmodule

bind regwin_xlate regwin_xlate_chk #(.FILE_SIZE(FILE_SIZE)) u_chk (
   .clk(clk), .rst_n(rst_n), .xl_req(xl_req),
   .cmd_win(cmd_win), .cmd_base(cmd_base), .cmd_call(cmd_call),
   .cmd_param(cmd_param), .core_ver(core_ver), .bundle_end(bundle_end),
   .xl_valid(xl_valid), .xl_idx(xl_idx), .fault(fault), .st(st_q)
);

// File: tb/test_regwin_xlate.sv
`timescale 1ns/1ps
module test_regwin_xlate;
   localparam int FS = 256;
   localparam int PW = $clog2(FS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xl_req = 1'b0, xl_based = 1'b0;
   logic [6:0]    xl_reg = '0;
   logic          cmd_win = 1'b0, cmd_base = 1'b0, cmd_call = 1'b0;
   logic [31:0]   cmd_param = '0, cmd_lit = '0;
   logic [3:0]    core_ver = '0;
   logic          bundle_end = 1'b0, bundle_branch = 1'b0;
   logic [1:0]    bundle_rot = '0;
   logic          xl_valid, fault, frame_fixed, frame_dbl;
   logic [PW-1:0] xl_idx;

   always #10 clk = ~clk;

   regwin_xlate #(.FILE_SIZE(FS)) i_regwin_xlate (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   typedef struct { int idx; bit flt; int rq; } exp_t;
   exp_t sbq[$];

   // reference state
   int m_wbs = 0, m_wsz = 0, m_rbs = 0, m_rsz = 0, m_rcur = 0;

   task automatic check(input bit ok, input int rq, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   function automatic void model(input bit based, input int r, output int idx, output bit flt);
      int span, i;
      if (!based) begin
         flt = (r >= 64) || (r >= 2 * m_wsz);
         idx = (r + 2 * m_wbs) % FS;
      end else begin
         span = 2 * m_rsz + 2;
         flt  = (r >= 2 * m_wsz) || (r >= span);
         i    = (r + 2 * (m_rsz + 1 - m_rcur)) % span;
         idx  = (i + 2 * m_wbs + 2 * m_rbs) % FS;
      end
      if (flt) idx = 0;
   endfunction

   // driver: push expectation, present one request for one cycle
   task automatic xlate(input bit based, input int r, input int rq);
      exp_t e;
      model(based, r, e.idx, e.flt);
      e.rq = rq;
      sbq.push_back(e);
      xl_req = 1'b1; xl_based = based; xl_reg = 7'(r);
      @(negedge clk);
      xl_req = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && xl_valid) begin
         if (sbq.size() == 0) begin
            check(1'b0, 11, "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(int'(xl_idx) == e.idx, e.rq, "index", int'(xl_idx), e.idx);
            check(fault == e.flt, e.rq, "fault", int'(fault), int'(e.flt));
         end
      end
   end

   task automatic set_win(input int wsz, input bit fx, input bit db, input int ver);
      cmd_win = 1'b1; core_ver = 4'(ver);
      cmd_lit = 32'hFFFF_F000 | (32'(wsz) << 5) | (32'(fx) << 4) | (32'(db) << 3) | 32'h7;
      m_wsz = wsz;
      @(negedge clk);
      cmd_win = 1'b0;
   endtask

   task automatic do_call(input logic [31:0] p);
      cmd_call = 1'b1; cmd_param = p;
      m_wbs = int'(p[6:0]);
      @(negedge clk);
      cmd_call = 1'b0;
   endtask

   task automatic set_base(input int rc, input int rs, input int rb);
      cmd_base = 1'b1;
      cmd_param = 32'hFFFC_0000 | (32'(rc) << 12) | (32'(rs) << 6) | 32'(rb);
      @(negedge clk);
      cmd_base = 1'b0;
      if (rc <= rs) begin
         m_rcur = rc; m_rsz = rs; m_rbs = rb;
         check(fault == 1'b0, 6, "accepted base-set fault", int'(fault), 0);
      end else begin
         check(fault == 1'b1, 6, "rejected base-set fault", int'(fault), 1);
      end
   endtask

   task automatic bundle(input bit br, input logic [1:0] rot);
      bundle_end = 1'b1; bundle_branch = br; bundle_rot = rot;
      if (br ? rot[0] : rot[1]) m_rcur = (m_rcur == m_rsz) ? 0 : m_rcur + 1;
      @(negedge clk);
      bundle_end = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, 11, "watchdog", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(xl_valid == 1'b0, 1, "valid after reset", int'(xl_valid), 0);
      check(fault == 1'b0, 1, "fault after reset", int'(fault), 0);
      check(frame_fixed == 1'b0, 1, "fixed after reset", int'(frame_fixed), 0);
      check(frame_dbl == 1'b0, 1, "dbl after reset", int'(frame_dbl), 0);
      xlate(1'b0, 0, 1);   // R1 zero window: faults
      xlate(1'b1, 0, 1);
      @(negedge clk);

      // R7 window-set fields and version gate
      set_win(40, 1'b1, 1'b1, 2);
      check(frame_fixed == 1'b1, 7, "fixed flag", int'(frame_fixed), 1);
      check(frame_dbl == 1'b0, 7, "dbl gated below v3", int'(frame_dbl), 0);
      set_win(40, 1'b0, 1'b1, 3);
      check(frame_fixed == 1'b0, 7, "fixed flag cleared", int'(frame_fixed), 0);
      check(frame_dbl == 1'b1, 7, "dbl taken at v3", int'(frame_dbl), 1);
      set_win(40, 1'b0, 1'b0, 1);
      check(frame_dbl == 1'b1, 7, "dbl held below v3", int'(frame_dbl), 1);

      // R8 call takes the low seven bits only
      do_call(32'hFFFF_FF64);
      // R2 window mapping including the file wrap
      xlate(1'b0, 5, 2);
      xlate(1'b0, 63, 2);
      xlate(1'b0, 27, 2);
      xlate(1'b0, 28, 8);
      // R3 bounds
      xlate(1'b0, 64, 3);
      xlate(1'b0, 80, 3);
      set_win(10, 1'b0, 1'b0, 3);
      xlate(1'b0, 19, 3);
      xlate(1'b0, 20, 3);
      xlate(1'b0, 19, 3);   // state unchanged after a fault

      // R6 base-set fields; R4 rotated mapping
      set_win(64, 1'b0, 1'b0, 3);
      set_base(2, 5, 3);
      for (int r = 0; r < 12; r++) xlate(1'b1, r, 4);
      // R5 bounds
      xlate(1'b1, 12, 5);
      set_win(5, 1'b0, 1'b0, 3);
      xlate(1'b1, 9, 5);
      xlate(1'b1, 10, 5);
      set_win(64, 1'b0, 1'b0, 3);

      // R9 branch-dependent advance and wrap
      bundle(1'b0, 2'b10); xlate(1'b1, 0, 9);
      bundle(1'b0, 2'b01); xlate(1'b1, 0, 9);
      bundle(1'b1, 2'b01); xlate(1'b1, 0, 9);
      bundle(1'b1, 2'b10); xlate(1'b1, 0, 9);
      for (int k = 0; k < 4; k++) begin
         bundle(1'b0, 2'b11);
         xlate(1'b1, 1, 9);
      end

      // R6 rejected base-set keeps the area
      set_base(7, 5, 9);
      xlate(1'b1, 3, 6);
      xlate(1'b1, 11, 6);

      // R10 base-set wins over an advancing bundle end
      cmd_base = 1'b1; bundle_end = 1'b1; bundle_branch = 1'b0; bundle_rot = 2'b10;
      cmd_param = (32'd1 << 12) | (32'd3 << 6) | 32'd2;
      xl_req = 1'b1; xl_based = 1'b1; xl_reg = 7'd4;
      begin
         exp_t e;
         model(1'b1, 4, e.idx, e.flt);   // uses pre-edge state
         e.rq = 10;
         sbq.push_back(e);
      end
      m_rcur = 1; m_rsz = 3; m_rbs = 2;
      @(negedge clk);
      cmd_base = 1'b0; bundle_end = 1'b0; xl_req = 1'b0;
      for (int r = 0; r < 8; r++) xlate(1'b1, r, 10);

      // R4 largest offsets wrap around the file
      do_call(32'h0000_007F);
      set_base(0, 63, 63);
      xlate(1'b1, 127, 4);
      xlate(1'b1, 0, 4);
      xlate(1'b0, 63, 2);
      set_base(63, 63, 63);
      xlate(1'b1, 127, 4);
      xlate(1'b1, 1, 4);

      // R11 back-to-back requests then idle
      xlate(1'b0, 1, 11);
      xlate(1'b1, 2, 11);
      @(negedge clk);
      check(xl_valid == 1'b0, 11, "valid drops when idle", int'(xl_valid), 0);
      repeat (2) @(negedge clk);
      check(sbq.size() == 0, 11, "outstanding results", sbq.size(), 0);
      done = 1;
      finish_run();
   end
endmodule